// File: doc/BRIEF.md
# Integer Add and Compare Unit

This block is the integer arithmetic slice of a RISC execute stage. Each cycle it takes two 64-bit operands and a 7-bit function code. It produces a 64-bit result, an overflow-trap flag and an illegal-function flag. The second operand arrives already chosen upstream: either a register value or a zero-extended 8-bit literal.

The unit covers several groups of operations:
- plain and scaled (A times 4 or A times 8) addition and subtraction, at both 32-bit and 64-bit widths;
- trapping variants of the unscaled add and subtract;
- five scalar compares that return 0 or 1;
- a bytewise unsigned compare that packs eight greater-or-equal decisions into the low byte.

The overflow flag is only a flag: trap delivery, operand fetch and writeback happen elsewhere. The decode and datapath are combinational. Their outputs pass through one output register, so a result appears one clock after its operands.

Top module: `int_addcmp_unit`

## Requirements
- R1: Code 0x20 returns A+B and code 0x29 returns A-B, both modulo 2^64.
- R2: Code 0x00 adds and code 0x09 subtracts on the low 32 bits of A and B. The 32-bit result is sign-extended from bit 31 into bits 63:32.
- R3: Scaled codes shift A left by 2 or by 3 before the operation, then behave as R1 or R2 at the width shown. Shift-by-2 codes: 0x02 (32-bit add), 0x22 (64-bit add), 0x0B (32-bit subtract), 0x2B (64-bit subtract). Shift-by-3 codes: 0x12 (32-bit add), 0x32 (64-bit add), 0x1B (32-bit subtract), 0x3B (64-bit subtract).
- R4: The trapping codes are 0x40 (32-bit add), 0x60 (64-bit add), 0x49 (32-bit subtract) and 0x69 (64-bit subtract).
  - They return the same wrapped result as 0x00, 0x20, 0x09 and 0x29.
  - They raise the overflow flag when the exact signed result does not fit the operation width.
  - For add, overflow means the operand signs are equal and the result sign differs from A. For subtract, it means the operand signs differ and the result sign differs from A.
- R5: The overflow flag is 0 for every code other than the four trapping codes.
- R6: The compare codes are:
  - 0x2D: equal;
  - 0x6D: signed less-or-equal;
  - 0x4D: signed less-than;
  - 0x3D: unsigned less-or-equal;
  - 0x1D: unsigned less-than.
  Each returns 1 when A relates to B that way and 0 otherwise, with bits 63:1 zero.
- R7: Code 0x0F sets result bit i (i = 0..7) when unsigned byte i of A (bits 8i+7:8i) is greater than or equal to byte i of B. Bits 63:8 are zero.
- R8: Any other code returns a zero result with the illegal flag set. The illegal flag is 0 for every listed code.
- R9: Outputs change only at a rising clock edge and reflect the inputs present before that edge. While reset is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_i | input | 7 | Function code |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B (register or zero-extended literal) |
| result_o | output | 64 | Registered result |
| ovf_o | output | 1 | Registered overflow-trap flag |
| illegal_o | output | 1 | Registered illegal-function flag |

## Verification
The following shape rules are checked by properties on every clock edge:
- an illegal code always gives a zero result;
- overflow only follows a trapping code;
- compare results are boolean;
- bytewise results stay in the low byte;
- 32-bit results are sign-extended;
- equality and the scaled-by-4 64-bit add match the operands of the previous cycle.

Whether each arithmetic value is exactly right is shown only by the bench. Its sweep covers all 128 function codes against a set of corner operand pairs and random pairs. It also shows the overflow boundaries at both widths, the scale shifts discarding high bits, and the signed-versus-unsigned difference on operands with the top bit set.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;

    localparam int FUNC_W = 7;

    typedef enum logic [1:0] {
        OPK_ARITH,
        OPK_CMP,
        OPK_BYTES,
        OPK_NONE
    } op_kind_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_SLE,
        CMP_SLT,
        CMP_ULE,
        CMP_ULT
    } cmp_sel_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       subtract;
        logic       narrow;
        logic [1:0] scale;
        logic       trap;
        cmp_sel_e   csel;
    } op_ctrl_t;

endpackage

// File: rtl/addcmp_decode.sv
module addcmp_decode
    import addcmp_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    output op_ctrl_t          ctrl_o
);

    function automatic op_ctrl_t arith(input logic sub, input logic nar,
                                       input logic [1:0] sc, input logic trp);
        op_ctrl_t c;
        c.kind     = OPK_ARITH;
        c.subtract = sub;
        c.narrow   = nar;
        c.scale    = sc;
        c.trap     = trp;
        c.csel     = CMP_EQ;
        return c;
    endfunction

    function automatic op_ctrl_t other(input op_kind_e k, input cmp_sel_e s);
        op_ctrl_t c;
        c.kind     = k;
        c.subtract = 1'b0;
        c.narrow   = 1'b0;
        c.scale    = 2'd0;
        c.trap     = 1'b0;
        c.csel     = s;
        return c;
    endfunction

    always_comb begin
        case (func_i)
            // plain add / subtract
            7'h00: ctrl_o = arith(1'b0, 1'b1, 2'd0, 1'b0);
            7'h20: ctrl_o = arith(1'b0, 1'b0, 2'd0, 1'b0);
            7'h09: ctrl_o = arith(1'b1, 1'b1, 2'd0, 1'b0);
            7'h29: ctrl_o = arith(1'b1, 1'b0, 2'd0, 1'b0);
            // trapping forms
            7'h40: ctrl_o = arith(1'b0, 1'b1, 2'd0, 1'b1);
            7'h60: ctrl_o = arith(1'b0, 1'b0, 2'd0, 1'b1);
            7'h49: ctrl_o = arith(1'b1, 1'b1, 2'd0, 1'b1);
            7'h69: ctrl_o = arith(1'b1, 1'b0, 2'd0, 1'b1);
            // scaled forms: scale field holds the shift distance
            7'h02: ctrl_o = arith(1'b0, 1'b1, 2'd2, 1'b0);
            7'h12: ctrl_o = arith(1'b0, 1'b1, 2'd3, 1'b0);
            7'h22: ctrl_o = arith(1'b0, 1'b0, 2'd2, 1'b0);
            7'h32: ctrl_o = arith(1'b0, 1'b0, 2'd3, 1'b0);
            7'h0B: ctrl_o = arith(1'b1, 1'b1, 2'd2, 1'b0);
            7'h1B: ctrl_o = arith(1'b1, 1'b1, 2'd3, 1'b0);
            7'h2B: ctrl_o = arith(1'b1, 1'b0, 2'd2, 1'b0);
            7'h3B: ctrl_o = arith(1'b1, 1'b0, 2'd3, 1'b0);
            // compares
            7'h2D: ctrl_o = other(OPK_CMP, CMP_EQ);
            7'h6D: ctrl_o = other(OPK_CMP, CMP_SLE);
            7'h4D: ctrl_o = other(OPK_CMP, CMP_SLT);
            7'h3D: ctrl_o = other(OPK_CMP, CMP_ULE);
            7'h1D: ctrl_o = other(OPK_CMP, CMP_ULT);
            7'h0F: ctrl_o = other(OPK_BYTES, CMP_EQ);
            default: ctrl_o = other(OPK_NONE, CMP_EQ);
        endcase
    end

endmodule

// File: rtl/addcmp_addsub.sv
module addcmp_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              subtract_i,
    input  logic              narrow_i,
    input  logic [1:0]        scale_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] full;
    logic              sa, sb, sr;

    always_comb begin
        a_sc = opa_i << scale_i;
        full = subtract_i ? (a_sc - opb_i) : (a_sc + opb_i);
        // low half of a full-width sum equals the half-width sum
        if (narrow_i) begin
            result_o = {{HALF_W{full[HALF_W-1]}}, full[HALF_W-1:0]};
            sa = a_sc[HALF_W-1];
            sb = opb_i[HALF_W-1];
            sr = full[HALF_W-1];
        end else begin
            result_o = full;
            sa = a_sc[DATA_W-1];
            sb = opb_i[DATA_W-1];
            sr = full[DATA_W-1];
        end
        ovf_o = subtract_i ? ((sa != sb) && (sr != sa))
                           : ((sa == sb) && (sr != sa));
    end

endmodule

// File: rtl/addcmp_compare.sv
module addcmp_compare
    import addcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    input  cmp_sel_e            csel_i,
    output logic                cmp_o,
    output logic [DATA_W/8-1:0] bytes_ge_o
);

    localparam int NBYTES = DATA_W / 8;

    logic eq, slt, ult;

    always_comb begin
        eq  = (opa_i == opb_i);
        slt = ($signed(opa_i) < $signed(opb_i));
        ult = (opa_i < opb_i);
        case (csel_i)
            CMP_EQ:  cmp_o = eq;
            CMP_SLE: cmp_o = slt | eq;
            CMP_SLT: cmp_o = slt;
            CMP_ULE: cmp_o = ult | eq;
            CMP_ULT: cmp_o = ult;
            default: cmp_o = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign bytes_ge_o[i] = (opa_i[8*i +: 8] >= opb_i[8*i +: 8]);
    end

endmodule

// File: rtl/int_addcmp_unit.sv
module int_addcmp_unit
    import addcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        func_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o,
    output logic              illegal_o
);

    localparam int NBYTES = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              ovf;
        logic              ill;
    } out_t;

    op_ctrl_t          ctrl;
    logic [DATA_W-1:0] arith_res;
    logic              arith_ovf;
    logic              cmp_bit;
    logic [NBYTES-1:0] bytes_ge;
    out_t              out_d, out_q;

    addcmp_decode u_decode (
        .func_i (func_i),
        .ctrl_o (ctrl)
    );

    addcmp_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .subtract_i (ctrl.subtract),
        .narrow_i   (ctrl.narrow),
        .scale_i    (ctrl.scale),
        .result_o   (arith_res),
        .ovf_o      (arith_ovf)
    );

    addcmp_compare #(.DATA_W(DATA_W)) u_compare (
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .csel_i     (ctrl.csel),
        .cmp_o      (cmp_bit),
        .bytes_ge_o (bytes_ge)
    );

    always_comb begin
        out_d = '0;
        case (ctrl.kind)
            OPK_ARITH: begin
                out_d.res = arith_res;
                out_d.ovf = ctrl.trap & arith_ovf;
            end
            OPK_CMP:   out_d.res[0] = cmp_bit;
            OPK_BYTES: out_d.res[NBYTES-1:0] = bytes_ge;
            default:   out_d.ill = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o  = out_q.res;
    assign ovf_o     = out_q.ovf;
    assign illegal_o = out_q.ill;

endmodule

// File: rtl/int_addcmp_unit_chk.sv
module int_addcmp_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [6:0]        func_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [DATA_W-1:0] result_o,
    input logic              ovf_o,
    input logic              illegal_o
);

    localparam int HALF_W = DATA_W / 2;

    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0));

    assert_ovf_trap_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(rst_n) && ($past(func_i) inside {7'h40, 7'h60, 7'h49, 7'h69})));

    assert_cmp_bool_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(func_i) inside {7'h2D, 7'h6D, 7'h4D, 7'h3D, 7'h1D}))
        |-> (result_o[DATA_W-1:1] == '0));

    assert_eq_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(func_i) == 7'h2D))
        |-> (result_o[0] == ($past(opa_i) == $past(opb_i))));

    assert_bytes_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(func_i) == 7'h0F)) |-> (result_o[DATA_W-1:8] == '0));

    assert_long_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(func_i) inside {7'h00, 7'h09, 7'h40, 7'h49,
                                                7'h02, 7'h12, 7'h0B, 7'h1B}))
        |-> (result_o[DATA_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}}));

    assert_s4add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(func_i) == 7'h22))
        |-> (result_o == (($past(opa_i) << 2) + $past(opb_i))));

endmodule

bind int_addcmp_unit int_addcmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_i    (func_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o),
    .illegal_o (illegal_o)
);

// File: tb/int_addcmp_unit_bench.sv
`timescale 1ns/1ps
module int_addcmp_unit_bench;

    logic        clk;
    logic        rst_n;
    logic [6:0]  func_i;
    logic [63:0] opa_i, opb_i;
    logic [63:0] result_o;
    logic        ovf_o, illegal_o;

    int checks   = 0;
    int failures = 0;

    int_addcmp_unit #(.DATA_W(64)) u_int_addcmp_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_i    (func_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .result_o  (result_o),
        .ovf_o     (ovf_o),
        .illegal_o (illegal_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string req, input string what, input logic [6:0] f,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s func=%02h actual=%h expected=%h", req, what, f, act, exp);
        end
    endtask

    // Expected outputs worked out from the requirements.
    task automatic model(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic ov, output logic ill,
                         output string req);
        bit arith, sub, lng, trap;
        int sh;
        logic [63:0]        as;
        logic signed [64:0] e64;
        logic signed [32:0] e32;
        arith = 0; sub = 0; lng = 0; trap = 0; sh = 0;
        r = '0; ov = 0; ill = 0; req = "R8";
        case (f)
            7'h00: begin arith = 1; lng = 1; req = "R2"; end
            7'h09: begin arith = 1; lng = 1; sub = 1; req = "R2"; end
            7'h20: begin arith = 1; req = "R1"; end
            7'h29: begin arith = 1; sub = 1; req = "R1"; end
            7'h40: begin arith = 1; lng = 1; trap = 1; req = "R4"; end
            7'h49: begin arith = 1; lng = 1; sub = 1; trap = 1; req = "R4"; end
            7'h60: begin arith = 1; trap = 1; req = "R4"; end
            7'h69: begin arith = 1; sub = 1; trap = 1; req = "R4"; end
            7'h02: begin arith = 1; lng = 1; sh = 2; req = "R3"; end
            7'h12: begin arith = 1; lng = 1; sh = 3; req = "R3"; end
            7'h22: begin arith = 1; sh = 2; req = "R3"; end
            7'h32: begin arith = 1; sh = 3; req = "R3"; end
            7'h0B: begin arith = 1; lng = 1; sub = 1; sh = 2; req = "R3"; end
            7'h1B: begin arith = 1; lng = 1; sub = 1; sh = 3; req = "R3"; end
            7'h2B: begin arith = 1; sub = 1; sh = 2; req = "R3"; end
            7'h3B: begin arith = 1; sub = 1; sh = 3; req = "R3"; end
            7'h2D: begin r = {63'd0, a == b}; req = "R6"; end
            7'h6D: begin r = {63'd0, $signed(a) <= $signed(b)}; req = "R6"; end
            7'h4D: begin r = {63'd0, $signed(a) <  $signed(b)}; req = "R6"; end
            7'h3D: begin r = {63'd0, a <= b}; req = "R6"; end
            7'h1D: begin r = {63'd0, a <  b}; req = "R6"; end
            7'h0F: begin
                req = "R7";
                for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
            end
            default: ill = 1;
        endcase
        if (arith) begin
            as = a << sh;
            if (lng) begin
                e32 = sub ? ($signed({as[31], as[31:0]}) - $signed({b[31], b[31:0]}))
                          : ($signed({as[31], as[31:0]}) + $signed({b[31], b[31:0]}));
                r  = {{32{e32[31]}}, e32[31:0]};
                ov = trap && (e32[32] != e32[31]);
            end else begin
                e64 = sub ? ($signed({as[63], as}) - $signed({b[63], b}))
                          : ($signed({as[63], as}) + $signed({b[63], b}));
                r  = e64[63:0];
                ov = trap && (e64[64] != e64[63]);
            end
        end
    endtask

    function automatic logic [127:0] corner(input int k);
        case (k)
            0:  return {64'h0, 64'h0};
            1:  return {64'h1, 64'h1};
            2:  return {64'hFFFF_FFFF_FFFF_FFFF, 64'h1};
            3:  return {64'h7FFF_FFFF_FFFF_FFFF, 64'h1};
            4:  return {64'h8000_0000_0000_0000, 64'h1};
            5:  return {64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};
            6:  return {64'h0000_0000_7FFF_FFFF, 64'h1};
            7:  return {64'h0000_0000_8000_0000, 64'h1};
            8:  return {64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201};
            9:  return {64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
            10: return {64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
            11: return {64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0};
            12: return {64'h0000_0000_4000_0000, 64'h0000_0000_4000_0000};
            13: return {64'h2000_0000_0000_0001, 64'h0};
            14: return {64'h5, 64'h0000_0000_FFFF_FFFF};
            default: return {64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD};
        endcase
    endfunction

    initial begin : watchdog
        #(200000 * 4);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [63:0] er;
        logic        eo, ei;
        string       rq;
        logic [127:0] pr;
        rst_n  = 1'b0;
        func_i = 7'h20;
        opa_i  = 64'h5;
        opb_i  = 64'h7;
        repeat (3) @(negedge clk);
        // R9: reset holds every output at zero
        check("R9", "reset result", func_i, result_o, 64'h0);
        check("R9", "reset ovf", func_i, {63'd0, ovf_o}, 64'h0);
        check("R9", "reset illegal", func_i, {63'd0, illegal_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: first edge after reset registers 5+7
        check("R9", "first result", func_i, result_o, 64'hC);
        func_i = 7'h29;
        opa_i  = 64'h10;
        opb_i  = 64'h3;
        #1;
        // R9: no change before the next rising edge
        check("R9", "held before edge", func_i, result_o, 64'hC);

        for (int f = 0; f < 128; f++) begin
            for (int p = 0; p < 24; p++) begin
                @(negedge clk);
                func_i = 7'(f);
                if (p < 16) begin
                    pr = corner(p);
                    opa_i = pr[127:64];
                    opb_i = pr[63:0];
                end else begin
                    opa_i = {$urandom, $urandom};
                    opb_i = (p < 20) ? {$urandom, $urandom} : 64'($urandom % 256);
                end
                model(func_i, opa_i, opb_i, er, eo, ei, rq);
                @(negedge clk);
                check(rq, "result", func_i, result_o, er);
                check((f == 'h40 || f == 'h60 || f == 'h49 || f == 'h69) ? "R4" : "R5",
                      "overflow", func_i, {63'd0, ovf_o}, {63'd0, eo});
                check("R8", "illegal", func_i, {63'd0, illegal_o}, {63'd0, ei});
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule